// File: doc/BRIEF.md
# Interrupt Source Delivery Router

This block keeps the configuration and pending state of a bank of interrupt inputs and decides which processor, or which processors, receive each request. Every source owns a vector/priority word and a destination word, both reachable over a small register port. Each input is conditioned by a polarity bit and sensed either as a level or as a rising edge. A qualified request leaves the block as a one-cycle delivery strobe per processor, tagged with the source index and its vector, on either the normal output group or the critical output group.

Delivery comes in two flavours. Directed delivery strobes every processor named in the destination word. Distributed delivery hands the request to a single processor, walking the destination word round-robin from the processor served last by that source. Critical routing bits in the destination word bypass the mask and steer the request to the critical outputs. Per-processor queuing lives downstream. It reports back through a small acknowledge input, which closes out an edge-sensed request.

Top module: `irq_router`

## Requirements
- R1: After reset every source reads back a vector/priority word of 0x80000000 (masked, inactive, all other fields zero), its destination word equals the `DEF_DEST` parameter decoded as in R3, and no strobe is raised. A register read returns its data one clock after the address is presented.
- R2: The vector/priority word has mask at bit 31, activity at bit 30, mode at bit 29, polarity at bit 23, sense at bit 22, priority at bits 19:16 and the vector at bits VEC_W-1:0. A bus write updates every field except activity, which the write leaves at its present value. Bits 28:24, 21:20 and 15:VEC_W read as zero.
- R3: In the destination word, bit i is the normal route to CPU i. When `CRIT_EN` is set, bit 30-i is the critical route to CPU i. All other bits are dropped on write and read as zero.
- R4: With sense=1 (level), the pending state follows the active input level. Once the input goes inactive, the activity bit clears, and a fresh assertion is delivered again. A strobe appears on the second rising clock edge after the input changes.
- R5: With sense=0 (edge), a rising transition of the active level sets pending, and a falling input does not clear it. An acknowledge naming the source clears both its pending and activity bits. An acknowledge has no effect on a level-sensed source.
- R6: With polarity=1 the input is active low. With polarity=0 it is active high.
- R7: A pending source is not delivered while it is masked (unless critically routed), while its priority is 0, while its activity bit is set, or while its destination word is zero. Any delivery sets the activity bit.
- R8: When the effective destination set holds only the CPU last served by that source, the request goes to that CPU alone, in either mode.
- R9: With mode=0 (directed), the strobe goes to every CPU in the effective destination set.
- R10: With mode=1 (distributed), the CPUs are searched cyclically, starting one past the last-served CPU. The first CPU found in the set receives the request and becomes the new last-served CPU. Last-served is 0 after reset.
- R11: If any critical route bit is set, the effective destination set is the set of critical bits. The request then strobes `crit_stb` instead of `norm_stb` and ignores the mask.
- R12: At most one source is delivered per cycle, and the lowest eligible index wins. A strobe lasts one cycle and carries the source index on `dlv_src` and its vector on `dlv_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NSRC | Raw interrupt inputs, one per source |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | SRC_W+1 | {source index, word select}: select 0 = vector/priority, 1 = destination |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the word at reg_addr |
| ack_vld | input | 1 | Downstream acknowledge of a delivered source |
| ack_src | input | SRC_W | Source index being acknowledged |
| norm_stb | output | NCPU | One-cycle normal delivery strobe per CPU |
| crit_stb | output | NCPU | One-cycle critical delivery strobe per CPU |
| dlv_src | output | SRC_W | Index of the delivered source |
| dlv_vec | output | VEC_W | Vector of the delivered source |

## Verification
The hardest state to reach from the ports is the distributed round-robin pointer. It lives inside each source and changes only on deliveries, so each expected target depends on the whole history of that source. The bench keeps its own last-served model per source and drives long random sequences of edge pulses with random destination masks, modes and critical bits, each followed by an acknowledge. It also covers the corners that are awkward to reach: a polarity flip made while the input is held, so that no false edge is seen, a write made while the source is active, and two sources raised in the same cycle.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int B_MASK  = 31;
  localparam int B_ACT   = 30;
  localparam int B_MODE  = 29;
  localparam int B_POL   = 23;
  localparam int B_SENSE = 22;
  localparam int B_PRIO  = 16;
  localparam int B_CTOP  = 30;

  typedef struct packed {
    logic       mask;
    logic       mode;
    logic       pol;
    logic       sense;
    logic [3:0] prio;
  } vcfg_t;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_router_pkg::*;
#(
  parameter int          NCPU     = 4,
  parameter int          VEC_W    = 8,
  parameter int          CW       = 2,
  parameter bit          CRIT_EN  = 1'b1,
  parameter logic [31:0] DEF_DEST = 32'h1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_raw,
  input  logic             we_vpr,
  input  logic             we_dst,
  input  logic [31:0]      wdata,
  input  logic             ack_hit,
  input  logic             dlv_hit,
  input  logic             upd_last,
  input  logic [CW-1:0]    new_last,
  output logic             elig,
  output logic             crit,
  output logic [NCPU-1:0]  dmask,
  output logic             mode,
  output logic [CW-1:0]    last,
  output logic [VEC_W-1:0] vec,
  output logic [31:0]      rd_vpr,
  output logic [31:0]      rd_dst
);
  function automatic logic [NCPU-1:0] crit_of(input logic [31:0] v);
    logic [NCPU-1:0] r;
    r = '0;
    for (int i = 0; i < NCPU; i++) r[i] = CRIT_EN ? v[B_CTOP-i] : 1'b0;
    return r;
  endfunction

  vcfg_t            cfg;
  logic [VEC_W-1:0] vec_r;
  logic             act_r, pend_r, lvl_q, lvl_prev;
  logic [NCPU-1:0]  nrm_r, crt_r;
  logic [CW-1:0]    last_r;
  logic             act_lvl, edge_evt, pending;

  assign act_lvl  = lvl_q ^ cfg.pol;
  assign edge_evt = act_lvl & ~lvl_prev;
  assign pending  = cfg.sense ? act_lvl : (pend_r | edge_evt);
  assign crit     = |crt_r;
  assign dmask    = crit ? crt_r : nrm_r;
  assign elig     = pending & (~cfg.mask | crit) & (cfg.prio != 4'd0) &
                    ~act_r & ((|nrm_r) | crit);
  assign mode     = cfg.mode;
  assign last     = last_r;
  assign vec      = vec_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '{mask: 1'b1, mode: 1'b0, pol: 1'b0, sense: 1'b0, prio: 4'd0};
      vec_r    <= '0;
      act_r    <= 1'b0;
      pend_r   <= 1'b0;
      lvl_q    <= 1'b0;
      lvl_prev <= 1'b0;
      last_r   <= '0;
      nrm_r    <= DEF_DEST[NCPU-1:0];
      crt_r    <= crit_of(DEF_DEST);
    end else begin
      lvl_q    <= irq_raw;
      lvl_prev <= act_lvl;
      if (we_vpr) begin
        cfg   <= '{mask: wdata[B_MASK], mode: wdata[B_MODE], pol: wdata[B_POL],
                   sense: wdata[B_SENSE], prio: wdata[B_PRIO+3:B_PRIO]};
        vec_r <= wdata[VEC_W-1:0];
      end
      if (we_dst) begin
        nrm_r <= wdata[NCPU-1:0];
        crt_r <= crit_of(wdata);
      end
      pend_r <= cfg.sense ? 1'b0 : ((pend_r & ~ack_hit) | edge_evt);
      if (dlv_hit) act_r <= 1'b1;
      else if ((cfg.sense & ~act_lvl) | (~cfg.sense & ack_hit)) act_r <= 1'b0;
      if (upd_last) last_r <= new_last;
    end
  end

  always_comb begin
    rd_vpr = '0;
    rd_vpr[B_MASK]  = cfg.mask;
    rd_vpr[B_ACT]   = act_r;
    rd_vpr[B_MODE]  = cfg.mode;
    rd_vpr[B_POL]   = cfg.pol;
    rd_vpr[B_SENSE] = cfg.sense;
    rd_vpr[B_PRIO+3:B_PRIO] = cfg.prio;
    rd_vpr[VEC_W-1:0] = vec_r;
    rd_dst = '0;
    rd_dst[NCPU-1:0] = nrm_r;
    for (int i = 0; i < NCPU; i++) rd_dst[B_CTOP-i] = crt_r[i];
  end
endmodule

// File: rtl/irq_first_pick.sv
module irq_first_pick #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic [N-1:0] req,
  output logic         vld,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) if (req[i]) idx = W'(i);
    vld = |req;
  end
endmodule

// File: rtl/irq_rr_target.sv
module irq_rr_target #(
  parameter int NCPU = 4,
  parameter int CW   = 2
) (
  input  logic [NCPU-1:0] dmask,
  input  logic            mode,
  input  logic [CW-1:0]   last,
  output logic [NCPU-1:0] tgt,
  output logic [CW-1:0]   new_last,
  output logic            upd
);
  logic [NCPU-1:0] last_oh;
  logic            found;
  int              idx;

  always_comb begin
    last_oh = '0;
    last_oh[last] = 1'b1;
    tgt      = '0;
    new_last = last;
    upd      = 1'b0;
    found    = 1'b0;
    idx      = 0;
    if (dmask == last_oh || !mode) begin
      tgt = dmask;
    end else begin
      for (int k = 1; k < NCPU; k++) begin
        idx = (int'(last) + k) % NCPU;
        if (!found && dmask[idx]) begin
          found    = 1'b1;
          tgt[idx] = 1'b1;
          new_last = CW'(idx);
          upd      = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int          NSRC     = 16,
  parameter int          NCPU     = 4,
  parameter int          VEC_W    = 8,
  parameter bit          CRIT_EN  = 1'b1,
  parameter logic [31:0] DEF_DEST = 32'h1,
  localparam int         SRC_W    = $clog2(NSRC),
  localparam int         CW       = $clog2(NCPU)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  irq_in,
  input  logic             reg_we,
  input  logic [SRC_W:0]   reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ack_vld,
  input  logic [SRC_W-1:0] ack_src,
  output logic [NCPU-1:0]  norm_stb,
  output logic [NCPU-1:0]  crit_stb,
  output logic [SRC_W-1:0] dlv_src,
  output logic [VEC_W-1:0] dlv_vec
);
  logic [NSRC-1:0]  elig_v, crit_v, mode_v;
  logic [NCPU-1:0]  dmask_a [NSRC];
  logic [CW-1:0]    last_a  [NSRC];
  logic [VEC_W-1:0] vec_a   [NSRC];
  logic [31:0]      rvpr_a  [NSRC];
  logic [31:0]      rdst_a  [NSRC];

  logic             pick_vld;
  logic [SRC_W-1:0] pick_idx;
  logic [NCPU-1:0]  sel_dmask, tgt;
  logic             sel_mode, sel_crit, rr_upd;
  logic [CW-1:0]    sel_last, rr_last;
  logic [VEC_W-1:0] sel_vec;
  logic [SRC_W-1:0] reg_idx;

  assign reg_idx = reg_addr[SRC_W:1];

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic hit;
    assign hit = pick_vld && (pick_idx == SRC_W'(g));
    irq_src_cell #(
      .NCPU(NCPU), .VEC_W(VEC_W), .CW(CW), .CRIT_EN(CRIT_EN), .DEF_DEST(DEF_DEST)
    ) u_cell (
      .clk      (clk),
      .rst      (rst),
      .irq_raw  (irq_in[g]),
      .we_vpr   (reg_we && reg_idx == SRC_W'(g) && !reg_addr[0]),
      .we_dst   (reg_we && reg_idx == SRC_W'(g) && reg_addr[0]),
      .wdata    (reg_wdata),
      .ack_hit  (ack_vld && ack_src == SRC_W'(g)),
      .dlv_hit  (hit),
      .upd_last (hit && rr_upd),
      .new_last (rr_last),
      .elig     (elig_v[g]),
      .crit     (crit_v[g]),
      .dmask    (dmask_a[g]),
      .mode     (mode_v[g]),
      .last     (last_a[g]),
      .vec      (vec_a[g]),
      .rd_vpr   (rvpr_a[g]),
      .rd_dst   (rdst_a[g])
    );
  end

  irq_first_pick #(.N(NSRC), .W(SRC_W)) u_pick (
    .req (elig_v),
    .vld (pick_vld),
    .idx (pick_idx)
  );

  assign sel_dmask = dmask_a[pick_idx];
  assign sel_mode  = mode_v[pick_idx];
  assign sel_crit  = crit_v[pick_idx];
  assign sel_last  = last_a[pick_idx];
  assign sel_vec   = vec_a[pick_idx];

  irq_rr_target #(.NCPU(NCPU), .CW(CW)) u_tgt (
    .dmask    (sel_dmask),
    .mode     (sel_mode),
    .last     (sel_last),
    .tgt      (tgt),
    .new_last (rr_last),
    .upd      (rr_upd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      norm_stb  <= '0;
      crit_stb  <= '0;
      dlv_src   <= '0;
      dlv_vec   <= '0;
      reg_rdata <= '0;
    end else begin
      norm_stb  <= (pick_vld && !sel_crit) ? tgt : '0;
      crit_stb  <= (pick_vld && sel_crit) ? tgt : '0;
      dlv_src   <= pick_idx;
      dlv_vec   <= sel_vec;
      reg_rdata <= reg_addr[0] ? rdst_a[reg_idx] : rvpr_a[reg_idx];
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NCPU = 4,
  parameter int SW   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NCPU-1:0] norm_stb,
  input logic [NCPU-1:0] crit_stb,
  input logic [SW-1:0]   dlv_src,
  input logic            pick_vld,
  input logic            sel_mode,
  input logic            sel_crit,
  input logic [NCPU-1:0] sel_dmask
);
  // R1: the first cycle out of reset carries no strobe
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (norm_stb == '0 && crit_stb == '0));

  // R7: a delivered source is not delivered again in the next cycle
  a_r7_no_redelivery: assert property (@(posedge clk) disable iff (rst)
    (|{norm_stb, crit_stb}) |=> !((|{norm_stb, crit_stb}) && dlv_src == $past(dlv_src)));

  // R9: directed delivery strobes the whole destination set
  a_r9_directed_all: assert property (@(posedge clk) disable iff (rst)
    (pick_vld && !sel_mode && !sel_crit) |=> (norm_stb == $past(sel_dmask)));

  // R10: distributed delivery reaches exactly one CPU
  a_r10_single_target: assert property (@(posedge clk) disable iff (rst)
    (pick_vld && sel_mode) |=> $onehot(norm_stb | crit_stb));

  // R11: critical requests use only the critical outputs
  a_r11_crit_only: assert property (@(posedge clk) disable iff (rst)
    (pick_vld && sel_crit) |=> (norm_stb == '0 && crit_stb != '0));
endmodule

bind irq_router irq_router_chk #(.NCPU(NCPU), .SW(SRC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .norm_stb  (norm_stb),
  .crit_stb  (crit_stb),
  .dlv_src   (dlv_src),
  .pick_vld  (pick_vld),
  .sel_mode  (sel_mode),
  .sel_crit  (sel_crit),
  .sel_dmask (sel_dmask)
);

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
  localparam int NSRC = 16, NCPU = 4, VEC_W = 8, SW = 4;

  logic            clk = 1'b0, rst = 1'b1;
  logic [NSRC-1:0] irq_in = '0;
  logic            reg_we = 1'b0;
  logic [SW:0]     reg_addr = '0;
  logic [31:0]     reg_wdata = '0, reg_rdata;
  logic            ack_vld = 1'b0;
  logic [SW-1:0]   ack_src = '0;
  logic [NCPU-1:0] norm_stb, crit_stb;
  logic [SW-1:0]   dlv_src;
  logic [VEC_W-1:0] dlv_vec;

  int total = 0, bad = 0;
  logic [NCPU-1:0] lastm [NSRC];

  always #2.5 clk = ~clk;

  irq_router #(.NSRC(NSRC), .NCPU(NCPU), .VEC_W(VEC_W), .CRIT_EN(1'b1), .DEF_DEST(32'h1)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_vld(ack_vld), .ack_src(ack_src),
    .norm_stb(norm_stb), .crit_stb(crit_stb), .dlv_src(dlv_src), .dlv_vec(dlv_vec));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkv(input bit m, input bit md, input bit p, input bit s,
                                      input logic [3:0] pr, input logic [7:0] v);
    return {m, 1'b0, md, 5'b0, p, s, 2'b0, pr, 8'b0, v};
  endfunction

  function automatic logic [31:0] mkd(input logic [3:0] n, input logic [3:0] c);
    logic [31:0] d = {28'b0, n};
    for (int i = 0; i < NCPU; i++) d[30-i] = c[i];
    return d;
  endfunction

  function automatic logic [3:0] model_tgt(input int s, input logic [3:0] n, input logic [3:0] c,
                                           input bit md);
    logic [3:0] dm = (c != 0) ? c : n;
    logic [3:0] t = '0;
    int li = 0;
    for (int i = 0; i < NCPU; i++) if (lastm[s][i]) li = i;
    if (dm == lastm[s] || !md) return dm;
    for (int k = 1; k < NCPU; k++) begin
      int j = (li + k) % NCPU;
      if (t == 0 && dm[j]) begin t[j] = 1'b1; lastm[s] = t; end
    end
    return t;
  endfunction

  task automatic wr(input int s, input bit sel, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = {SW'(s), sel}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int s, input bit sel, output logic [31:0] d);
    reg_addr = {SW'(s), sel};
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic ack(input int s);
    ack_vld = 1'b1; ack_src = SW'(s);
    @(negedge clk);
    ack_vld = 1'b0;
  endtask

  task automatic watch_none(input string req, input int n);
    logic [7:0] acc = '0;
    repeat (n) begin @(negedge clk); acc |= {crit_stb, norm_stb}; end
    chk(req, {24'b0, acc}, 32'h0);
  endtask

  task automatic expect_dlv(input string req, input int s, input logic [7:0] stb,
                            input logic [7:0] v);
    chk(req, {24'b0, crit_stb, norm_stb}, {24'b0, stb});
    chk(req, {28'b0, dlv_src}, 32'(s));
    chk(req, {24'b0, dlv_vec}, {24'b0, v});
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NSRC; i++) lastm[i] = 4'b0001;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(0, 0, d); chk("R1 vpr reset", d, 32'h8000_0000);
    rd(3, 1, d); chk("R1 dest reset", d, 32'h0000_0001);
    chk("R1 no strobe", {24'b0, crit_stb, norm_stb}, 32'h0);

    // R3 destination field layout
    wr(4, 1, 32'hFFFF_FFFF); rd(4, 1, d); chk("R3 dest layout", d, 32'h7800_000F);

    // R7 masked source blocked
    wr(0, 0, mkv(1, 0, 0, 0, 3, 8'h10));
    irq_in[0] = 1'b1; watch_none("R7 masked", 4); irq_in[0] = 1'b0;

    // R2 activity not writable, other fields stored
    wr(1, 0, 32'hFFFF_FFFF); rd(1, 0, d); chk("R2 field write", d, 32'hA0CF_00FF);

    // R4 / R9 level directed delivery
    wr(2, 1, 32'h5); wr(2, 0, mkv(0, 0, 0, 1, 5, 8'h2A));
    irq_in[2] = 1'b1; @(negedge clk); @(negedge clk);
    expect_dlv("R9 directed level", 2, 8'h05, 8'h2A);
    @(negedge clk); chk("R12 one cycle", {24'b0, crit_stb, norm_stb}, 32'h0);
    rd(2, 0, d); chk("R7 activity set", d, 32'h4045_002A);
    wr(2, 0, mkv(0, 0, 0, 1, 5, 8'h2A)); rd(2, 0, d); chk("R2 activity kept", d, 32'h4045_002A);
    watch_none("R7 active blocks", 6);
    irq_in[2] = 1'b0; @(negedge clk); @(negedge clk);
    rd(2, 0, d); chk("R4 deassert clears activity", d, 32'h0045_002A);
    irq_in[2] = 1'b1; @(negedge clk); @(negedge clk);
    expect_dlv("R4 level redelivery", 2, 8'h05, 8'h2A);
    irq_in[2] = 1'b0; repeat (3) @(negedge clk);

    // R7 priority zero and empty destination
    wr(3, 1, 32'h2); wr(3, 0, mkv(0, 0, 0, 1, 0, 8'h33));
    irq_in[3] = 1'b1; watch_none("R7 prio zero", 4);
    wr(3, 1, 32'h0); wr(3, 0, mkv(0, 0, 0, 1, 4, 8'h33));
    watch_none("R7 empty dest", 4);
    irq_in[3] = 1'b0; repeat (2) @(negedge clk);

    // R6 polarity: active low, no false edge when flipped while held
    irq_in[4] = 1'b1; @(negedge clk);
    wr(4, 1, 32'h8); wr(4, 0, mkv(0, 0, 1, 1, 6, 8'h44));
    watch_none("R6 inactive high", 4);
    irq_in[4] = 1'b0; @(negedge clk); @(negedge clk);
    expect_dlv("R6 active low", 4, 8'h08, 8'h44);
    irq_in[4] = 1'b1; repeat (3) @(negedge clk);

    // R10 distributed round robin, R5 edge and acknowledge
    wr(5, 1, 32'hF); wr(5, 0, mkv(0, 1, 0, 0, 7, 8'h55));
    for (int k = 0; k < 4; k++) begin
      irq_in[5] = 1'b1; @(negedge clk); @(negedge clk);
      expect_dlv("R10 round robin", 5, 8'(1 << ((k + 1) % 4)), 8'h55);
      irq_in[5] = 1'b0;
      if (k == 0) begin
        watch_none("R5 edge held until ack", 4);
        rd(5, 0, d); chk("R5 activity held", d[31:0] & 32'h4000_0000, 32'h4000_0000);
      end
      ack(5); @(negedge clk);
    end
    wr(5, 1, 32'h1);
    irq_in[5] = 1'b1; @(negedge clk); @(negedge clk);
    expect_dlv("R8 last only", 5, 8'h01, 8'h55);
    irq_in[5] = 1'b0; ack(5);
    wr(5, 1, 32'h2);
    irq_in[5] = 1'b1; @(negedge clk); @(negedge clk);
    expect_dlv("R10 after single", 5, 8'h02, 8'h55);
    irq_in[5] = 1'b0; ack(5);
    rd(5, 0, d); chk("R5 ack clears", d, mkv(0, 1, 0, 0, 7, 8'h55));

    // R11 critical route ignores mask
    wr(6, 1, mkd(4'h1, 4'h2)); wr(6, 0, mkv(1, 0, 0, 0, 9, 8'h66));
    irq_in[6] = 1'b1; @(negedge clk); @(negedge clk);
    expect_dlv("R11 critical", 6, 8'h20, 8'h66);
    irq_in[6] = 1'b0; ack(6);

    // R12 lowest index first
    wr(7, 1, 32'h4); wr(7, 0, mkv(0, 0, 0, 1, 2, 8'h77));
    irq_in[2] = 1'b1; irq_in[7] = 1'b1; @(negedge clk); @(negedge clk);
    expect_dlv("R12 lower index first", 2, 8'h05, 8'h2A);
    @(negedge clk);
    expect_dlv("R12 next index", 7, 8'h04, 8'h77);
    irq_in[2] = 1'b0; irq_in[7] = 1'b0; repeat (3) @(negedge clk);

    // random trials on sources 8..15
    for (int t = 0; t < 150; t++) begin
      int s = 8 + int'($urandom % 8);
      logic [3:0] n = 4'($urandom), c = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      bit md = 1'($urandom), m = ($urandom % 5 == 0);
      logic [3:0] pr = 4'(1 + $urandom % 15);
      logic [7:0] v = 8'($urandom);
      logic [3:0] e;
      if (n == 0 && c == 0) n = 4'h1;
      wr(s, 1, mkd(n, c)); wr(s, 0, mkv(m, md, 0, 0, pr, v));
      irq_in[s] = 1'b1; @(negedge clk); @(negedge clk);
      if (m && c == 0) chk("R7 random masked", {24'b0, crit_stb, norm_stb}, 32'h0);
      else begin
        e = model_tgt(s, n, c, md);
        expect_dlv("R8 R9 R10 R11 random", s, (c != 0) ? {e, 4'h0} : {4'h0, e}, v);
      end
      irq_in[s] = 1'b0; ack(s); @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule